// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 512 general-purpose 32-bit registers behind a simple single-cycle register bus, occupying a 4 KiB byte window. Software writes a word and reads it back; most locations are plain storage. A handful of locations behave differently. One control location turns particular written values into a one-cycle request to reset the system or to shut it down. Three status locations return the stored word with two fixed bits forced high. Four words come out of reset with non-zero values.

The bus has no back-pressure. A request is accepted in any cycle where `req_valid` is high. Writes complete at once. A read returns its data one clock later with `rsp_valid` high. Addresses are byte offsets. The two low bits are ignored. The storage index wraps every 512 words, so offsets from 0x800 up alias onto the same words as offsets below 0x800. Control decoding and read forcing, however, look at the full window offset.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, the word at byte offset 0x100 holds 0x05F20121, 0x104 holds 0x00000002, 0x108 holds 0x05F30121, 0x10C holds 0x05F40121, and every other word holds zero.
- R2: A write stores all 32 data bits into the word at index (offset / 4) mod 512, and a later read of that word returns the stored value.
- R3: A read accepted in cycle N sets `rsp_valid` high with the data in cycle N+1. A write never sets `rsp_valid`.
- R4: A write to offset 0xF00 with data 1 or 2 sets `sys_reset_req` high for exactly the following cycle.
- R5: A write to offset 0xF00 with data 3 sets `sys_halt_req` high for exactly the following cycle.
- R6: A write to offset 0xF00 with any other data raises neither request. The control word is still stored in every case and reads back unchanged.
- R7: Reads at offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000 (bits 29 and 28 set). Reads at all other offsets, including 0x104, return the stored word unmodified.
- R8: Address bits 1:0 are ignored for storage, control decode and read forcing. For example, 0xF03 acts as 0xF00 and 0x102 acts as 0x100.
- R9: Control decode and read forcing compare the whole 12-bit window offset, so aliased offsets (0x700 for the control word, 0x900 for 0x100) reach the shared storage without side effects.
- R10: Reads never raise a request pulse, and with no bus activity both request outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A bus request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | 32 | Read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_halt_req | output | 1 | One-cycle shutdown request |

## Verification
A single write to the control word both stores the value and raises a request pulse, and both effects land in the same cycle. The bench writes each of the values 1, 2, 3 and several others to 0xF00. It checks the pulse lines in the cycle after the write. It then reads the word back and compares it against the written value, so a lost store or a missing pulse is each caught. Aliasing is exercised by storing through 0x700 and 0x900 and reading through the canonical offsets. The checks confirm that storage is shared while the pulse and the forcing stay absent.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned SC_ADDR_W = 12;
    localparam int unsigned SC_DATA_W = 32;
    localparam int unsigned SC_WORDS  = 512;

    // Control word and the status offsets whose reads get forced bits
    localparam logic [11:0] SC_CTRL_OFS = 12'hF00;
    localparam int unsigned SC_NFORCE   = 3;
    localparam logic [11:0] SC_FORCE_OFS [SC_NFORCE] = '{12'h100, 12'h108, 12'h10C};
    localparam logic [31:0] SC_FORCE_MASK = 32'h3000_0000;

    typedef enum logic [1:0] {
        SC_REQ_NONE  = 2'd0,
        SC_REQ_RESET = 2'd1,
        SC_REQ_HALT  = 2'd2
    } sc_req_e;

    // Value a storage word takes while reset is held
    function automatic logic [31:0] sc_reset_value(input int unsigned idx);
        logic [31:0] v;
        case (idx)
            32'd64:  v = 32'h05F2_0121;
            32'd65:  v = 32'h0000_0002;
            32'd66:  v = 32'h05F3_0121;
            32'd67:  v = 32'h05F4_0121;
            default: v = 32'h0000_0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = SC_DATA_W,
    parameter int unsigned WORDS  = SC_WORDS,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(WORDS); i++) begin
                mem_q[i] <= DATA_W'(sc_reset_value(i));
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_word = mem_q[rd_idx];

endmodule

// File: rtl/sysctl_ctl_decode.sv
module sysctl_ctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = SC_ADDR_W,
    parameter int unsigned DATA_W = SC_DATA_W
) (
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output sc_req_e           req
);

    logic at_ctrl;

    assign at_ctrl = (addr >> 2) == ADDR_W'(SC_CTRL_OFS >> 2);

    always_comb begin
        req = SC_REQ_NONE;
        if (wr_fire && at_ctrl) begin
            if (wdata == DATA_W'(1) || wdata == DATA_W'(2)) begin
                req = SC_REQ_RESET;
            end else if (wdata == DATA_W'(3)) begin
                req = SC_REQ_HALT;
            end
        end
    end

endmodule

// File: rtl/sysctl_rd_force.sv
module sysctl_rd_force
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = SC_ADDR_W,
    parameter int unsigned DATA_W = SC_DATA_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] word_out
);

    logic [SC_NFORCE-1:0] hit;

    for (genvar g = 0; g < int'(SC_NFORCE); g++) begin : g_hit
        assign hit[g] = (addr >> 2) == ADDR_W'(SC_FORCE_OFS[g] >> 2);
    end

    assign word_out = (|hit) ? (word_in | DATA_W'(SC_FORCE_MASK)) : word_in;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = SC_ADDR_W,
    parameter int unsigned DATA_W = SC_DATA_W,
    parameter int unsigned WORDS  = SC_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sys_reset_req,
    output logic              sys_halt_req
);

    localparam int unsigned IDX_W = $clog2(WORDS);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              rst_pulse;
        logic              halt_pulse;
    } st_t;

    st_t st_d, st_q;

    logic              wr_fire;
    logic              rd_fire;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] shown_word;
    sc_req_e           ctl_req;

    assign wr_fire  = req_valid && req_write;
    assign rd_fire  = req_valid && !req_write;
    assign word_idx = req_addr[IDX_W+1:2];

    sysctl_store #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire),
        .wr_idx  (word_idx),
        .wr_data (req_wdata),
        .rd_idx  (word_idx),
        .rd_word (raw_word)
    );

    sysctl_ctl_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctl (
        .wr_fire (wr_fire),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .req     (ctl_req)
    );

    sysctl_rd_force #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_force (
        .addr     (req_addr),
        .word_in  (raw_word),
        .word_out (shown_word)
    );

    always_comb begin
        st_d            = st_q;
        st_d.rvalid     = rd_fire;
        st_d.rst_pulse  = (ctl_req == SC_REQ_RESET);
        st_d.halt_pulse = (ctl_req == SC_REQ_HALT);
        if (rd_fire) begin
            st_d.rdata = shown_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.rvalid;
    assign rsp_rdata     = st_q.rdata;
    assign sys_reset_req = st_q.rst_pulse;
    assign sys_halt_req  = st_q.halt_pulse;

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = SC_ADDR_W,
    parameter int unsigned DATA_W = SC_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              sys_reset_req,
    input logic              sys_halt_req
);

    logic ctl_wr;
    logic force_rd;

    assign ctl_wr   = req_valid && req_write && ((req_addr >> 2) == ADDR_W'(SC_CTRL_OFS >> 2));
    assign force_rd = req_valid && !req_write &&
                      (((req_addr >> 2) == ADDR_W'(SC_FORCE_OFS[0] >> 2)) ||
                       ((req_addr >> 2) == ADDR_W'(SC_FORCE_OFS[1] >> 2)) ||
                       ((req_addr >> 2) == ADDR_W'(SC_FORCE_OFS[2] >> 2)));

    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(ctl_wr && (req_wdata == DATA_W'(1) || req_wdata == DATA_W'(2)))); // R4

    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_halt_req |-> $past(ctl_wr && req_wdata == DATA_W'(3))); // R5

    AST_HALT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && req_wdata == DATA_W'(3)) |=> sys_halt_req); // R5

    AST_OTHER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && req_wdata != DATA_W'(1) && req_wdata != DATA_W'(2) && req_wdata != DATA_W'(3))
        |=> (!sys_reset_req && !sys_halt_req)); // R6

    AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R3

    AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid); // R3

    AST_FORCED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        force_rd |=> (rsp_valid && rsp_rdata[29:28] == 2'b11)); // R7

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .sys_reset_req (sys_reset_req),
    .sys_halt_req  (sys_halt_req)
);

// File: tb/sim_sysctl_regfile.sv
module sim_sysctl_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        sys_reset_req;
    logic        sys_halt_req;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       tag;
        logic [11:0] addr;
        logic [31:0] exp;
    } exp_t;

    exp_t sb_q [$];

    always #10 clk = ~clk;

    sysctl_regfile u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .sys_reset_req (sys_reset_req),
        .sys_halt_req  (sys_halt_req)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk("R3", "unexpected rsp_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, $sformatf("read 0x%03h", e.addr), rsp_rdata, e.exp);
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             input logic exp_rst, input logic exp_halt, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(tag, "sys_reset_req after write", 32'(sys_reset_req), 32'(exp_rst));
        chk(tag, "sys_halt_req after write", 32'(sys_halt_req), 32'(exp_halt));
        chk("R3", "rsp_valid after write", 32'(rsp_valid), 32'd0);
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_t item;
        item.tag = tag; item.addr = a; item.exp = e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        sb_q.push_back(item);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "no request pulse on read", 32'({sys_reset_req, sys_halt_req}), 32'd0);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        chk(tag, "pulses low when idle", 32'({sys_reset_req, sys_halt_req}), 32'd0);
        chk("R3", "rsp_valid low when idle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        idle_check("R10");

        // R1 reset contents (forced bits apply at 0x100/0x108/0x10C per R7)
        bus_read(12'h100, 32'h35F2_0121, "R1");
        bus_read(12'h104, 32'h0000_0002, "R1");
        bus_read(12'h108, 32'h35F3_0121, "R1");
        bus_read(12'h10C, 32'h35F4_0121, "R1");
        bus_read(12'h000, 32'h0, "R1");
        bus_read(12'h110, 32'h0, "R1");
        bus_read(12'hF00, 32'h0, "R1");

        // R2 plain storage
        bus_write(12'h004, 32'hA5A5_1234, 1'b0, 1'b0, "R2");
        bus_read(12'h004, 32'hA5A5_1234, "R2");
        bus_write(12'h7FC, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2");
        bus_read(12'h7FC, 32'hFFFF_FFFF, "R2");
        idle_check("R3");

        // R7 forcing only at three offsets
        bus_write(12'h104, 32'h0, 1'b0, 1'b0, "R7");
        bus_read(12'h104, 32'h0, "R7");
        bus_write(12'h100, 32'h0, 1'b0, 1'b0, "R7");
        bus_read(12'h100, 32'h3000_0000, "R7");
        bus_write(12'h108, 32'hCFFF_FFFF, 1'b0, 1'b0, "R7");
        bus_read(12'h108, 32'hFFFF_FFFF, "R7");
        bus_write(12'h10C, 32'h0000_00FF, 1'b0, 1'b0, "R7");
        bus_read(12'h10C, 32'h3000_00FF, "R7");

        // R8 low bits ignored, R9 aliasing without side effects
        bus_write(12'h102, 32'h0000_ABCD, 1'b0, 1'b0, "R8");
        bus_read(12'h101, 32'h3000_ABCD, "R8");
        bus_write(12'h904, 32'h0000_1111, 1'b0, 1'b0, "R9");
        bus_read(12'h104, 32'h0000_1111, "R9");
        bus_write(12'h900, 32'h0000_0005, 1'b0, 1'b0, "R9");
        bus_read(12'h900, 32'h0000_0005, "R9");
        bus_read(12'h100, 32'h3000_0005, "R9");

        // R4 reset requests, one cycle only
        bus_write(12'hF00, 32'd1, 1'b1, 1'b0, "R4");
        idle_check("R4");
        bus_write(12'hF00, 32'd2, 1'b1, 1'b0, "R4");
        bus_read(12'hF00, 32'd2, "R6");

        // R5 shutdown request
        bus_write(12'hF00, 32'd3, 1'b0, 1'b1, "R5");
        idle_check("R5");
        bus_read(12'hF00, 32'd3, "R6");
        bus_write(12'hF03, 32'd3, 1'b0, 1'b1, "R8");

        // R6 other values
        bus_write(12'hF00, 32'd0, 1'b0, 1'b0, "R6");
        bus_write(12'hF00, 32'd4, 1'b0, 1'b0, "R6");
        bus_write(12'hF00, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6");
        bus_read(12'hF00, 32'hFFFF_FFFF, "R6");
        bus_write(12'hF00, 32'h0000_0101, 1'b0, 1'b0, "R6");
        bus_read(12'hF00, 32'h0000_0101, "R6");

        // R9 aliased control location: stores but no pulse
        bus_write(12'h700, 32'd1, 1'b0, 1'b0, "R9");
        bus_write(12'h700, 32'd3, 1'b0, 1'b0, "R9");
        bus_read(12'hF00, 32'd3, "R9");

        // R1 again after a second reset
        do_reset();
        idle_check("R10");
        bus_read(12'h104, 32'h0000_0002, "R1");
        bus_read(12'h004, 32'h0, "R1");
        bus_read(12'hF00, 32'h0, "R1");

        repeat (3) @(negedge clk);
        chk("R3", "responses drained", 32'(sb_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule